// File: doc/BRIEF.md
# Half to Single Precision Widener

This block turns a 16-bit IEEE 754 half-precision bit pattern into the 32-bit single-precision pattern of the same value. Every half value has an exact single-precision form, so there is no rounding. The block uses only field extraction, a leading-zero count, shifts and small integer adds. It needs no floating-point datapath.

The block works out the input class first: zero, subnormal, normal, or infinity/NaN. It then rebuilds the exponent and mantissa fields for that class. Half-precision subnormals are renormalised into normal single-precision values. NaN payload bits pass through unchanged and are not replaced by a canonical NaN.

A parameter selects the output timing. With `REG_OUT=1` (the default) there is one register stage, and the valid strobe travels through it with the data. With `REG_OUT=0` the path is purely combinational. Many lanes of a memory-bound datapath can use one copy each to widen packed half operands before a single-precision stage.

Top module: `hp2sp_widen`

## Requirements
- R1: Output bit 31 always equals input bit 15, for every input class including zero and NaN.
- R2: For an input biased exponent in the range 1..30, the output biased exponent (bits 30:23) is the input exponent (bits 14:10) plus 112.
- R3: For finite nonzero inputs and for infinity/NaN, the output's low 13 bits are zero. For normal inputs and infinity/NaN, output bits 22:13 equal input bits 9:0.
- R4: An input exponent of 31 gives an output exponent of 255. The 10 input mantissa bits land in output bits 22:13, so infinity stays infinity and the NaN payload is kept bit for bit.
- R5: A subnormal input (exponent 0, mantissa nonzero) with its leading one at mantissa bit p (0..9) gives output exponent 103+p. Output bits 22:13 hold the mantissa bits below that leading one, shifted up so the leading one is dropped, with zeros filled in below.
- R6: An input of +0 or -0 gives output bits 30:0 all zero, with the sign kept.
- R7: With REG_OUT=1, valid_o and single_o show valid_i and the converted half_i one clock later. An active-low reset clears valid_o and single_o to zero.
- R8: With REG_OUT=1, single_o holds its previous value in any cycle that follows a clock edge where valid_i was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input word is valid |
| half_i | input | 16 | Half-precision bit pattern |
| valid_o | output | 1 | Output word is valid |
| single_o | output | 32 | Single-precision bit pattern |

## Verification
The hardest cases to reach are the subnormal inputs whose leading one sits at each of the ten mantissa positions, since each position gives a different exponent and shift amount. NaN codes with scattered payload bits are the other hard group. The stimulus does not pick these cases by hand. It sweeps all 65536 input codes in order, so every leading-one position, both signs and every payload are covered. About one cycle in 97 is an idle cycle that drives valid_i low with an unrelated pattern on half_i, to show that the output holds its value.

// File: rtl/hp2sp_pkg.sv
package hp2sp_pkg;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned HALF_EW  = 5;
  localparam int unsigned HALF_MW  = 10;
  localparam int unsigned SGL_W    = 32;
  localparam int unsigned SGL_EW   = 8;
  localparam int unsigned SGL_MW   = 23;
  localparam int unsigned HALF_BIAS = (1 << (HALF_EW - 1)) - 1;
  localparam int unsigned SGL_BIAS  = (1 << (SGL_EW - 1)) - 1;
  localparam int unsigned BIAS_DIFF = SGL_BIAS - HALF_BIAS;
  localparam int unsigned PAD_W     = SGL_MW - HALF_MW;
  localparam int unsigned LZ_W      = $clog2(HALF_MW + 1);

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_SUB  = 2'd1,
    CLS_NORM = 2'd2,
    CLS_SPEC = 2'd3
  } half_cls_e;
endpackage

// File: rtl/hp2sp_classify.sv
module hp2sp_classify
  import hp2sp_pkg::*;
(
  input  logic [HALF_EW-1:0] exp_i,
  input  logic [HALF_MW-1:0] man_i,
  output half_cls_e          cls_o
);
  always_comb begin
    if (&exp_i)       cls_o = CLS_SPEC;
    else if (|exp_i)  cls_o = CLS_NORM;
    else if (|man_i)  cls_o = CLS_SUB;
    else              cls_o = CLS_ZERO;
  end
endmodule

// File: rtl/hp2sp_lzc.sv
module hp2sp_lzc #(
  parameter int unsigned W   = 10,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  // scan upward so the highest set bit wins
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < int'(W); i++) begin
      if (vec_i[i]) cnt_o = CNT_W'(int'(W) - 1 - i);
    end
  end
endmodule

// File: rtl/hp2sp_core.sv
module hp2sp_core
  import hp2sp_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  output logic [SGL_W-1:0]  single_o
);
  logic               sgn;
  logic [HALF_EW-1:0] h_exp;
  logic [HALF_MW-1:0] h_man;
  half_cls_e          cls;
  logic [LZ_W-1:0]    lz;
  logic [LZ_W-1:0]    shamt;
  logic [HALF_MW-1:0] sub_man;
  logic [SGL_EW-1:0]  s_exp;
  logic [HALF_MW-1:0] s_man;

  assign sgn   = half_i[HALF_W-1];
  assign h_exp = half_i[HALF_W-2 -: HALF_EW];
  assign h_man = half_i[HALF_MW-1:0];

  hp2sp_classify u_cls (
    .exp_i (h_exp),
    .man_i (h_man),
    .cls_o (cls)
  );

  hp2sp_lzc #(.W(HALF_MW), .CNT_W(LZ_W)) u_lzc (
    .vec_i (h_man),
    .cnt_o (lz)
  );

  // shift one past the leading one so it drops out as the hidden bit
  assign shamt   = lz + LZ_W'(1);
  assign sub_man = h_man << shamt;

  always_comb begin
    unique case (cls)
      CLS_SPEC: begin s_exp = {SGL_EW{1'b1}};                    s_man = h_man;   end
      CLS_NORM: begin s_exp = SGL_EW'(h_exp) + SGL_EW'(BIAS_DIFF); s_man = h_man;   end
      CLS_SUB:  begin s_exp = SGL_EW'(BIAS_DIFF) - SGL_EW'(lz);    s_man = sub_man; end
      default:  begin s_exp = '0;                                s_man = '0;      end
    endcase
  end

  assign single_o = {sgn, s_exp, s_man, {PAD_W{1'b0}}};
endmodule

// File: rtl/hp2sp_widen.sv
module hp2sp_widen
  import hp2sp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              valid_o,
  output logic [SGL_W-1:0]  single_o
);
  logic [SGL_W-1:0] conv;

  hp2sp_core u_core (
    .half_i   (half_i),
    .single_o (conv)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic             vld_q;
      logic [SGL_W-1:0] dat_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else begin
          vld_q <= valid_i;
          if (valid_i) dat_q <= conv;  // hold on idle cycles
        end
      end
      assign valid_o  = vld_q;
      assign single_o = dat_q;
    end else begin : g_comb
      assign valid_o  = valid_i;
      assign single_o = conv;
    end
  endgenerate
endmodule

// File: rtl/hp2sp_widen_chk.sv
module hp2sp_widen_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [15:0] half_i,
  input logic        valid_o,
  input logic [31:0] single_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_reg_chk
      // R7
      reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !armed_q |-> (!valid_o && single_o == 32'h0));
      // R7
      valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> valid_o == $past(valid_i));
      // R1
      sign_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && valid_o) |-> single_o[31] == $past(half_i[15]));
      // R4
      spec_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && valid_o) |-> ((single_o[30:23] == 8'hff) == ($past(half_i[14:10]) == 5'h1f)));
      // R6
      zero_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && valid_o && $past(half_i[14:0]) == 15'h0) |-> single_o[30:0] == 31'h0);
      // R8
      hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !valid_o) |-> $stable(single_o));
      // R3
      pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> single_o[12:0] == 13'h0);
    end else begin : g_comb_chk
      // R1
      sign_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        single_o[31] == half_i[15]);
      // R4
      spec_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (single_o[30:23] == 8'hff) == (half_i[14:10] == 5'h1f));
      // R3
      pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        single_o[12:0] == 13'h0);
      // R7
      valid_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == valid_i);
    end
  endgenerate
endmodule

bind hp2sp_widen hp2sp_widen_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .half_i   (half_i),
  .valid_o  (valid_o),
  .single_o (single_o)
);

// File: tb/hp2sp_widen_tb_top.sv
module hp2sp_widen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] half_i = 16'h0;
  logic        valid_o;
  logic [31:0] single_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  hp2sp_widen #(.REG_OUT(1'b1)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .half_i   (half_i),
    .valid_o  (valid_o),
    .single_o (single_o)
  );

  function automatic logic [31:0] ref_widen(input logic [15:0] h);
    int unsigned e, m, p, ex, mt;
    e = h[14:10];
    m = h[9:0];
    if (e == 31) return {h[15], 8'hff, h[9:0], 13'h0};
    if (e == 0 && m == 0) return {h[15], 31'h0};
    if (e == 0) begin
      p = 9;
      while (((m >> p) & 1) == 0) p--;
      ex = 103 + p;
      mt = (m << (10 - p)) & 32'h3ff;
    end else begin
      ex = e + 112;
      mt = m;
    end
    return {h[15], 8'(ex), 10'(mt), 13'h0};
  endfunction

  function automatic string req_of(input logic [15:0] h, input logic [31:0] got,
                                   input logic [31:0] exp_w);
    if (got[31] != exp_w[31])    return "R1";
    if (got[12:0] != 13'h0)      return "R3";
    if (h[14:10] == 5'h1f)       return "R4";
    if (h[14:10] != 5'h0)        return (got[30:23] != exp_w[30:23]) ? "R2" : "R3";
    if (h[9:0] == 10'h0)         return "R6";
    return "R5";
  endfunction

  logic        exp_v;
  logic [31:0] exp_d;
  logic [15:0] last_h;
  logic        last_v;

  task automatic check_out();
    n_chk++;
    if (valid_o !== exp_v) begin
      n_bad++;
      $display("FAIL R7 valid_o got %0b exp %0b", valid_o, exp_v);
    end
    if (single_o !== exp_d) begin
      n_bad++;
      if (!last_v)
        $display("FAIL R8 idle hold got %08h exp %08h", single_o, exp_d);
      else
        $display("FAIL %s in %04h got %08h exp %08h",
                 req_of(last_h, single_o, exp_d), last_h, single_o, exp_d);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] h);
    valid_i = v;
    half_i  = h;
    last_v  = v;
    last_h  = h;
    exp_v   = v;
    if (v) exp_d = ref_widen(h);
  endtask

  initial begin
    exp_v = 1'b0; exp_d = 32'h0; last_v = 1'b0; last_h = 16'h0;
    repeat (3) @(negedge clk_i);
    // R7: reset state
    check_out();
    rst_ni = 1'b1;
    for (int code = 0; code < 65536; code++) begin
      @(negedge clk_i);
      check_out();
      if (code % 97 == 13) begin
        drive(1'b0, 16'(code) ^ 16'h5a5a);  // R8 idle cycle
        @(negedge clk_i);
        check_out();
      end
      drive(1'b1, 16'(code));
    end
    @(negedge clk_i);
    check_out();
    drive(1'b0, 16'h7e01);
    repeat (2) begin
      @(negedge clk_i);
      check_out();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired got running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule